// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block controls a bank of general-purpose pins through a small register bus. Software sees three locations: an output-value register, a direction register and a read-only view of the sampled pad levels. The block drives the pad model with a per-pin driver enable, a driven value and a pull-up request. Pad levels pass through a two-flop synchronizer before they become readable.

Besides whole-register writes, the bus offers a one-cycle single-bit set or clear of either the output-value or the direction register, leaving every other bit alone. Writing ones to the input-view address inverts the matching output-value bits. A global pull-up kill input forces every pull-up request low. The block has no state machine. Its only sequential elements are the two storage registers and the synchronizer. Each bus cycle is one transition: the next register values are computed from the current values and the strobes.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after it is released, the output-value and direction registers read 0x00, and pad_oe, pad_out and pad_pu are all 0x00.
- R2: A write with bus_we=1 to address 0 (output value) or address 1 (direction) replaces that register with bus_wdata. The new value reads back from the following cycle onward.
- R3: A write with bus_we=1 to address 2 (pin view) inverts each output-value bit whose bus_wdata bit is 1 and keeps each bit whose bus_wdata bit is 0. The pin view itself is not changed by the write.
- R4: bit_set=1 sets, and bit_clr=1 clears, bit bit_idx of the register chosen by bit_dir (0 = output value, 1 = direction) in one clock cycle. All other bits of that register are unchanged. When both strobes are 1, the clear wins.
- R5: When a bit set or bit clear and a whole-register write or a toggle write hit the same bit in one cycle, the bit set or bit clear decides that bit. The write or toggle still applies to the other bits.
- R6: pad_oe equals the direction register. pad_out carries output-value bit n when direction bit n is 1, and is 0 otherwise.
- R7: pad_pu bit n is 1 only when direction bit n is 0, output-value bit n is 1 and pud_all is 0.
- R8: A change on pad_in is invisible at address 2 after one rising edge and visible after the second rising edge.
- R9: Address 3 reads as 0x00, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 output value, 1 direction, 2 pin view, 3 unused |
| bus_we | input | 1 | Whole-register write strobe |
| bus_wdata | input | 8 | Write data |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_dir | input | 1 | Single-bit target: 0 output value, 1 direction |
| bit_idx | input | 3 | Single-bit index |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pud_all | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_pu | output | 8 | Per-pin pull-up request |

## Verification
The hardest case to reach from the ports is the collision of a toggle write and a single-bit strobe on the same output-value bit in the same cycle. The bench gets there by pointing bus_addr at the pin view with bus_we high while bit_dir selects the output-value register. It raises both strobes in the same cycle, and it picks bit patterns where the toggle and the strobe would give opposite results. The synchronizer latency is pinned down by changing pad_in just after an edge and reading the pin view after exactly one edge and then after two.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        ADDR_OUT  = 2'd0,
        ADDR_DIR  = 2'd1,
        ADDR_PIN  = 2'd2,
        ADDR_NONE = 2'd3
    } gpio_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= raw_in;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

    // R8: the last stage carries what entered the first stage one edge earlier
    assert_sync_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[STAGES-1] == $past(stage_q[(STAGES > 1) ? STAGES-2 : 0]) || STAGES == 1);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bit_set,
    input  logic             bit_clr,
    input  logic             bit_dir,
    input  logic [IDXW-1:0]  bit_idx,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] out_nxt;
    logic [WIDTH-1:0] dir_nxt;

    always_comb begin
        out_nxt = out_q;
        dir_nxt = dir_q;
        if (bus_we) begin
            unique case (gpio_addr_e'(bus_addr))
                ADDR_OUT:  out_nxt = bus_wdata;
                ADDR_DIR:  dir_nxt = bus_wdata;
                ADDR_PIN:  out_nxt = out_q ^ bus_wdata;
                ADDR_NONE: ;
            endcase
        end
        if (bit_clr) begin
            if (bit_dir) dir_nxt[bit_idx] = 1'b0;
            else         out_nxt[bit_idx] = 1'b0;
        end else if (bit_set) begin
            if (bit_dir) dir_nxt[bit_idx] = 1'b1;
            else         out_nxt[bit_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            out_q <= out_nxt;
            dir_q <= dir_nxt;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (out_q == '0 && dir_q == '0));

    assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_OUT && !bit_set && !bit_clr) |=> out_q == $past(bus_wdata));

    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_PIN && !bit_set && !bit_clr)
        |=> (out_q == ($past(out_q) ^ $past(bus_wdata)) && $stable(dir_q)));

    assert_bit_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_set && !bit_clr && !bus_we && bit_dir)
        |=> dir_q == ($past(dir_q) | (WIDTH'(1) << $past(bit_idx))));

    assert_bit_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_clr && !bus_we && !bit_dir)
        |=> out_q == ($past(out_q) & ~(WIDTH'(1) << $past(bit_idx))));

    assert_strobe_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_set && !bit_clr && !bit_dir && bus_we && bus_addr == ADDR_PIN)
        |=> out_q[$past(bit_idx)] == 1'b1);

    assert_unused_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_NONE && !bit_set && !bit_clr)
        |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] out_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic             pud_all,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    genvar n;
    generate
        for (n = 0; n < WIDTH; n++) begin : g_pin
            always_comb begin
                pad_oe[n]  = dir_q[n];
                pad_out[n] = dir_q[n] & out_q[n];
                pad_pu[n]  = ~dir_q[n] & out_q[n] & ~pud_all;
            end
        end
    endgenerate

    assert_pu_not_on_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    assert_pu_killed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pud_all |-> pad_pu == '0);

    assert_no_drive_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bit_set,
    input  logic             bit_clr,
    input  logic             bit_dir,
    input  logic [IDXW-1:0]  bit_idx,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic             pud_all,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_q;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bit_set(bit_set), .bit_clr(bit_clr), .bit_dir(bit_dir), .bit_idx(bit_idx),
        .out_q(out_q), .dir_q(dir_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(pin_q)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .clk(clk), .rst_n(rst_n), .out_q(out_q), .dir_q(dir_q), .pud_all(pud_all),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    always_comb begin
        unique case (gpio_addr_e'(bus_addr))
            ADDR_OUT:  bus_rdata = out_q;
            ADDR_DIR:  bus_rdata = dir_q;
            ADDR_PIN:  bus_rdata = pin_q;
            ADDR_NONE: bus_rdata = '0;
        endcase
    end

    assert_oe_follows_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_DIR |-> bus_rdata == pad_oe);

    assert_unused_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == ADDR_NONE |-> bus_rdata == '0);
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bit_set = 1'b0;
    logic       bit_clr = 1'b0;
    logic       bit_dir = 1'b0;
    logic [2:0] bit_idx = 3'd0;
    logic [7:0] bus_rdata;
    logic       pud_all = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pu;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bit_set(bit_set), .bit_clr(bit_clr),
        .bit_dir(bit_dir), .bit_idx(bit_idx), .bus_rdata(bus_rdata),
        .pud_all(pud_all), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, registers load at the next posedge
    task automatic cyc(input logic [1:0] a, input logic we, input logic [7:0] d,
                       input logic s, input logic c, input logic bd, input logic [2:0] bi);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d;
        bit_set = s; bit_clr = c; bit_dir = bd; bit_idx = bi;
        @(negedge clk);
        bus_we = 1'b0; bit_set = 1'b0; bit_clr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); check("R1 out", v, 8'h00);
        rd(2'd1, v); check("R1 dir", v, 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 out pad", pad_out, 8'h00);
        check("R1 pu", pad_pu, 8'h00);
    endtask

    task automatic t_write;
        logic [7:0] v;
        cyc(2'd0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 3'd0);
        rd(2'd0, v); check("R2 out write", v, 8'hA5);
        cyc(2'd1, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 3'd0);
        rd(2'd1, v); check("R2 dir write", v, 8'h3C);
        rd(2'd0, v); check("R2 out kept", v, 8'hA5);
    endtask

    task automatic t_toggle;
        logic [7:0] v;
        cyc(2'd2, 1'b1, 8'h0F, 1'b0, 1'b0, 1'b0, 3'd0);
        rd(2'd0, v); check("R3 toggle", v, 8'hAA);
        rd(2'd2, v); check("R3 pin unchanged", v, 8'h00);
        rd(2'd1, v); check("R3 dir unchanged", v, 8'h3C);
    endtask

    task automatic t_bitops;
        logic [7:0] v;
        cyc(2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 3'd7);
        rd(2'd1, v); check("R4 dir set bit7", v, 8'hBC);
        cyc(2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd3);
        rd(2'd0, v); check("R4 out clear bit3", v, 8'hA2);
        cyc(2'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 3'd1);
        rd(2'd0, v); check("R4 clear wins", v, 8'hA0);
        rd(2'd1, v); check("R4 dir untouched", v, 8'hBC);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        cyc(2'd0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0);
        cyc(2'd2, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 3'd3);
        rd(2'd0, v); check("R5 clear beats toggle", v, 8'hF7);
        cyc(2'd2, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 3'd0);
        rd(2'd0, v); check("R5 set beats toggle", v, 8'hF7);
        cyc(2'd0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 3'd5);
        rd(2'd0, v); check("R5 set beats write", v, 8'h20);
    endtask

    task automatic t_pads;
        cyc(2'd1, 1'b1, 8'hF0, 1'b0, 1'b0, 1'b0, 3'd0);
        cyc(2'd0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R6 oe", pad_oe, 8'hF0);
        check("R6 out", pad_out, 8'h30);
        check("R7 pu", pad_pu, 8'h0C);
        pud_all = 1'b1;
        #0.5;
        check("R7 global kill", pad_pu, 8'h00);
        check("R6 out kept under kill", pad_out, 8'h30);
        pud_all = 1'b0;
        #0.5;
        check("R7 pu back", pad_pu, 8'h0C);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        rd(2'd2, v); check("R8 one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd2, v); check("R8 two edges", v, 8'h5A);
    endtask

    task automatic t_unused;
        logic [7:0] v;
        cyc(2'd3, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd0);
        rd(2'd3, v); check("R9 reads zero", v, 8'h00);
        rd(2'd0, v); check("R9 out unchanged", v, 8'h3C);
        rd(2'd1, v); check("R9 dir unchanged", v, 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write;
        t_toggle;
        t_bitops;
        t_priority;
        t_pads;
        t_sync;
        t_unused;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule